// File: doc/BRIEF.md
# Thermal Operating Point Sequencer

This block moves one core from its present frequency/voltage operating point to a new one. It keeps the latest software performance request and compares it with a thermally optimized ratio whenever the thermal throttle flag is high. From these it picks one effective target ratio. It then reaches that target through two request/acknowledge handshakes: one asks the regulator for a voltage code, the other asks the clock generator for a ratio. The order of the two steps depends on whether the target is above or below the present point. Execution is halted only while a frequency step is in progress.

While throttling, a software request above the thermal ratio waits and the thermal ratio governs. A software request below the thermal ratio takes effect at once. When throttling ends, the block returns to the most recent software request. No ratio ever goes below a lowest-frequency floor. The voltage code for a ratio comes from a fixed formula that stands in for a characterisation table.

Top module: `opp_sequencer`

## Requirements
- R1: When the target ratio is above the applied ratio, the voltage step for the target is acknowledged before the frequency request for that target is raised.
- R2: When the target ratio is below the applied ratio, the frequency step is acknowledged before the voltage request for that target is raised.
- R3: `halt_o` is high while a frequency request is outstanding and low while a voltage request is outstanding. The two requests are never high together.
- R4: While `throttle_i` is high, a software ratio above the clamped thermal ratio is held. The effective target is then the clamped thermal ratio, and no step toward the software ratio occurs.
- R5: While `throttle_i` is high, a software ratio below the clamped thermal ratio becomes the target at once.
- R6: When `throttle_i` falls, the target becomes the most recent software ratio.
- R7: A thermal ratio or software ratio below `FLOOR_RATIO` (default 8) is treated as `FLOOR_RATIO`, so no step ever requests a lower ratio.
- R8: A raised request stays high, with a stable value, until its acknowledge is seen. It drops on the cycle after the acknowledge.
- R9: A target change that arrives during a transition is sampled only after the current transition (both steps) completes, and is then served.
- R10: `at_min_o` is high exactly when `throttle_i` is high and the applied ratio equals `FLOOR_RATIO`.
- R11: After reset the applied ratio is `RESET_RATIO` (default 16), the voltage code matches it, and no request or halt is active.
- R12: The voltage code requested for ratio r is (r >> 2) + 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| throttle_i | input | 1 | Thermal throttle active |
| therm_ratio_i | input | RATIO_W | Thermally optimized ratio |
| sw_valid_i | input | 1 | One-cycle strobe for a new software request |
| sw_ratio_i | input | RATIO_W | Software requested ratio |
| volt_req_o | output | 1 | Voltage step request |
| volt_code_o | output | VCODE_W | Requested voltage code |
| volt_ack_i | input | 1 | Voltage step done |
| freq_req_o | output | 1 | Frequency step request |
| freq_ratio_o | output | RATIO_W | Requested ratio |
| freq_ack_i | input | 1 | Frequency step done |
| halt_o | output | 1 | Halt instruction execution |
| applied_ratio_o | output | RATIO_W | Ratio currently in effect |
| at_min_o | output | 1 | Throttled at the floor ratio |

## Verification
The assertions assume that each acknowledge is a single-cycle pulse that arrives only while its own request is high. They also assume that the thermal ratio and throttle flag change only at clock edges. The bench's regulator and clock models wait a programmable number of cycles after a request, raise acknowledge for one cycle, and then lower it before any new request can be seen. The software strobe and thermal inputs are driven on the falling edge, and only by the scenario tasks.

// File: rtl/opp_pkg.sv
package opp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_VUP,
    ST_FUP,
    ST_FDN,
    ST_VDN
  } opp_state_e;
endpackage

// File: rtl/opp_target_sel.sv
module opp_target_sel #(
  parameter int RATIO_W     = 8,
  parameter int FLOOR_RATIO = 8,
  parameter int RESET_RATIO = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               throttle_i,
  input  logic [RATIO_W-1:0] therm_ratio_i,
  input  logic               sw_valid_i,
  input  logic [RATIO_W-1:0] sw_ratio_i,
  output logic [RATIO_W-1:0] target_o
);
  localparam logic [RATIO_W-1:0] FLOOR_R = RATIO_W'(FLOOR_RATIO);
  localparam logic [RATIO_W-1:0] RESET_R = RATIO_W'(RESET_RATIO);

  logic [RATIO_W-1:0] sw_q, sw_d;
  logic [RATIO_W-1:0] therm_c;

  // software request held; raised to floor (R7)
  always_comb begin
    sw_d = sw_q;
    if (sw_valid_i) sw_d = (sw_ratio_i < FLOOR_R) ? FLOOR_R : sw_ratio_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sw_q <= RESET_R;
    else if (sw_valid_i) sw_q <= sw_d;
  end

  // thermal ratio clamp and effective target selection (R4, R5, R6)
  always_comb begin
    therm_c  = (therm_ratio_i < FLOOR_R) ? FLOOR_R : therm_ratio_i;
    target_o = sw_q;
    if (throttle_i && (therm_c < sw_q)) target_o = therm_c;
  end

  a_r7_target_floor: assert property (@(posedge clk) disable iff (!rst_n)
    target_o >= FLOOR_R);
  a_r4_throttle_cap: assert property (@(posedge clk) disable iff (!rst_n)
    (throttle_i && (therm_ratio_i >= FLOOR_R)) |-> (target_o <= therm_ratio_i));
endmodule

// File: rtl/opp_step_fsm.sv
module opp_step_fsm
  import opp_pkg::*;
#(
  parameter int RATIO_W     = 8,
  parameter int VCODE_W     = 7,
  parameter int RESET_RATIO = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [RATIO_W-1:0] target_i,
  output logic               volt_req_o,
  output logic [VCODE_W-1:0] volt_code_o,
  input  logic               volt_ack_i,
  output logic               freq_req_o,
  output logic [RATIO_W-1:0] freq_ratio_o,
  input  logic               freq_ack_i,
  output logic               halt_o,
  output logic [RATIO_W-1:0] applied_o
);
  localparam logic [RATIO_W-1:0] RESET_R = RATIO_W'(RESET_RATIO);

  function automatic logic [VCODE_W-1:0] vmap(input logic [RATIO_W-1:0] r);
    logic [VCODE_W-1:0] v;
    v = VCODE_W'(r >> 2);
    return v + VCODE_W'(1);
  endfunction

  opp_state_e         state_q, state_d;
  logic [RATIO_W-1:0] tgt_q, tgt_d;
  logic [RATIO_W-1:0] appl_q, appl_d;
  logic [VCODE_W-1:0] vcode_q, vcode_d;
  logic               tgt_en, appl_en, vcode_en;

  always_comb begin
    state_d  = state_q;
    tgt_d    = tgt_q;
    appl_d   = appl_q;
    vcode_d  = vcode_q;
    tgt_en   = 1'b0;
    appl_en  = 1'b0;
    vcode_en = 1'b0;
    unique case (state_q)
      ST_IDLE: if (target_i != appl_q) begin
        tgt_d   = target_i;
        tgt_en  = 1'b1;
        state_d = (target_i > appl_q) ? ST_VUP : ST_FDN;
      end
      ST_VUP: if (volt_ack_i) begin
        vcode_d  = vmap(tgt_q);
        vcode_en = 1'b1;
        state_d  = ST_FUP;
      end
      ST_FUP: if (freq_ack_i) begin
        appl_d  = tgt_q;
        appl_en = 1'b1;
        state_d = ST_IDLE;
      end
      ST_FDN: if (freq_ack_i) begin
        appl_d  = tgt_q;
        appl_en = 1'b1;
        state_d = ST_VDN;
      end
      ST_VDN: if (volt_ack_i) begin
        vcode_d  = vmap(tgt_q);
        vcode_en = 1'b1;
        state_d  = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      tgt_q   <= RESET_R;
      appl_q  <= RESET_R;
      vcode_q <= vmap(RESET_R);
    end else begin
      state_q <= state_d;
      if (tgt_en)   tgt_q   <= tgt_d;
      if (appl_en)  appl_q  <= appl_d;
      if (vcode_en) vcode_q <= vcode_d;
    end
  end

  assign volt_req_o   = (state_q == ST_VUP) || (state_q == ST_VDN);
  assign freq_req_o   = (state_q == ST_FUP) || (state_q == ST_FDN);
  assign volt_code_o  = vmap(tgt_q);
  assign freq_ratio_o = tgt_q;
  assign halt_o       = freq_req_o;
  assign applied_o    = appl_q;

  a_r1_volt_before_freq: assert property (@(posedge clk) disable iff (!rst_n)
    (freq_req_o && (freq_ratio_o > appl_q)) |-> (vcode_q == vmap(freq_ratio_o)));
  a_r2_freq_before_volt: assert property (@(posedge clk) disable iff (!rst_n)
    (volt_req_o && (volt_code_o < vcode_q)) |-> (vmap(appl_q) == volt_code_o));
  a_r3_no_halt_on_volt: assert property (@(posedge clk) disable iff (!rst_n)
    volt_req_o |-> (!halt_o && !freq_req_o));
  a_r8_volt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (volt_req_o && !volt_ack_i) |=> (volt_req_o && $stable(volt_code_o)));
  a_r8_freq_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (freq_req_o && !freq_ack_i) |=> (freq_req_o && $stable(freq_ratio_o)));
  a_r8_drop_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (freq_req_o && freq_ack_i) |=> !freq_req_o);
endmodule

// File: rtl/opp_sequencer.sv
module opp_sequencer #(
  parameter int RATIO_W     = 8,
  parameter int VCODE_W     = 7,
  parameter int FLOOR_RATIO = 8,
  parameter int RESET_RATIO = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               throttle_i,
  input  logic [RATIO_W-1:0] therm_ratio_i,
  input  logic               sw_valid_i,
  input  logic [RATIO_W-1:0] sw_ratio_i,
  output logic               volt_req_o,
  output logic [VCODE_W-1:0] volt_code_o,
  input  logic               volt_ack_i,
  output logic               freq_req_o,
  output logic [RATIO_W-1:0] freq_ratio_o,
  input  logic               freq_ack_i,
  output logic               halt_o,
  output logic [RATIO_W-1:0] applied_ratio_o,
  output logic               at_min_o
);
  localparam logic [RATIO_W-1:0] FLOOR_R = RATIO_W'(FLOOR_RATIO);

  logic               rst_meta_q, rst_sync_q;
  logic [RATIO_W-1:0] target;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  opp_target_sel #(
    .RATIO_W(RATIO_W), .FLOOR_RATIO(FLOOR_RATIO), .RESET_RATIO(RESET_RATIO)
  ) i_sel (
    .clk(clk), .rst_n(rst_sync_q), .throttle_i(throttle_i),
    .therm_ratio_i(therm_ratio_i), .sw_valid_i(sw_valid_i),
    .sw_ratio_i(sw_ratio_i), .target_o(target)
  );

  opp_step_fsm #(
    .RATIO_W(RATIO_W), .VCODE_W(VCODE_W), .RESET_RATIO(RESET_RATIO)
  ) i_fsm (
    .clk(clk), .rst_n(rst_sync_q), .target_i(target),
    .volt_req_o(volt_req_o), .volt_code_o(volt_code_o), .volt_ack_i(volt_ack_i),
    .freq_req_o(freq_req_o), .freq_ratio_o(freq_ratio_o), .freq_ack_i(freq_ack_i),
    .halt_o(halt_o), .applied_o(applied_ratio_o)
  );

  assign at_min_o = throttle_i && (applied_ratio_o == FLOOR_R);

  a_r7_freq_floor: assert property (@(posedge clk) disable iff (!rst_sync_q)
    freq_req_o |-> (freq_ratio_o >= FLOOR_R));
  a_r10_min_needs_throttle: assert property (@(posedge clk) disable iff (!rst_sync_q)
    at_min_o |-> (throttle_i && (applied_ratio_o <= FLOOR_R)));
endmodule

// File: tb/test_opp_sequencer.sv
module test_opp_sequencer;
  localparam int RW = 8;
  localparam int VW = 7;

  typedef struct {
    bit    is_freq;
    int    val;
    string tag;
  } step_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          throttle_i = 1'b0;
  logic [RW-1:0] therm_ratio_i = '0;
  logic          sw_valid_i = 1'b0;
  logic [RW-1:0] sw_ratio_i = '0;
  logic          volt_ack_i = 1'b0;
  logic          freq_ack_i = 1'b0;
  logic          volt_req_o, freq_req_o, halt_o, at_min_o;
  logic [VW-1:0] volt_code_o;
  logic [RW-1:0] freq_ratio_o, applied_ratio_o;

  int    errors = 0;
  int    checks = 0;
  int    delay  = 2;
  int    vcnt   = 0;
  int    fcnt   = 0;
  step_t exp_q[$];

  always #10 clk = ~clk;  // 50 MHz

  opp_sequencer i_opp_sequencer (
    .clk(clk), .rst_n(rst_n), .throttle_i(throttle_i), .therm_ratio_i(therm_ratio_i),
    .sw_valid_i(sw_valid_i), .sw_ratio_i(sw_ratio_i),
    .volt_req_o(volt_req_o), .volt_code_o(volt_code_o), .volt_ack_i(volt_ack_i),
    .freq_req_o(freq_req_o), .freq_ratio_o(freq_ratio_o), .freq_ack_i(freq_ack_i),
    .halt_o(halt_o), .applied_ratio_o(applied_ratio_o), .at_min_o(at_min_o)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp_v);
    end
  endtask

  function automatic int vmap(input int r);
    return (r >> 2) + 1;  // R12
  endfunction

  task automatic expect_step(input bit is_freq, input int val, input string tag);
    step_t s;
    s.is_freq = is_freq; s.val = val; s.tag = tag;
    exp_q.push_back(s);
  endtask

  task automatic expect_up(input int r, input string tag);    // R1
    expect_step(1'b0, vmap(r), tag);
    expect_step(1'b1, r, tag);
  endtask

  task automatic expect_down(input int r, input string tag);  // R2
    expect_step(1'b1, r, tag);
    expect_step(1'b0, vmap(r), tag);
  endtask

  task automatic sw_request(input int r);
    @(negedge clk);
    sw_valid_i = 1'b1; sw_ratio_i = RW'(r);
    @(negedge clk);
    sw_valid_i = 1'b0;
  endtask

  task automatic drain();
    int n = 0;
    while (exp_q.size() != 0 && n < 3000) begin
      @(negedge clk);
      n++;
    end
    if (exp_q.size() != 0) begin
      check(1'b0, "watchdog", exp_q.size(), 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
    repeat (4) @(negedge clk);
  endtask

  // regulator / clock models and scoreboard monitor
  always @(negedge clk) begin
    step_t e;
    if (volt_ack_i) begin
      volt_ack_i <= 1'b0; vcnt = 0;
    end else if (volt_req_o) begin
      vcnt++;
      if (vcnt >= delay) begin
        volt_ack_i <= 1'b1;
        check(!halt_o && !freq_req_o, "R3 volt step halt", halt_o, 0);
        if (exp_q.size() == 0) check(1'b0, "R8 unexpected volt step", volt_code_o, -1);
        else begin
          e = exp_q.pop_front();
          check(!e.is_freq && (volt_code_o == e.val), {e.tag, " volt step"},
                volt_code_o, e.is_freq ? -1 : e.val);
        end
      end
    end
    if (freq_ack_i) begin
      freq_ack_i <= 1'b0; fcnt = 0;
    end else if (freq_req_o) begin
      fcnt++;
      if (fcnt >= delay) begin
        freq_ack_i <= 1'b1;
        check(halt_o == 1'b1, "R3 freq step halt", halt_o, 1);
        if (exp_q.size() == 0) check(1'b0, "R8 unexpected freq step", freq_ratio_o, -1);
        else begin
          e = exp_q.pop_front();
          check(e.is_freq && (freq_ratio_o == e.val), {e.tag, " freq step"},
                freq_ratio_o, e.is_freq ? e.val : -1);
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R11 reset state
    check(applied_ratio_o == 16, "R11 applied", applied_ratio_o, 16);
    check(!volt_req_o && !freq_req_o && !halt_o, "R11 idle", {volt_req_o, freq_req_o, halt_o}, 0);
    check(at_min_o == 1'b0, "R10 reset at_min", at_min_o, 0);

    expect_up(24, "R1");   sw_request(24); drain();
    check(applied_ratio_o == 24, "R1 applied", applied_ratio_o, 24);
    expect_down(12, "R2"); sw_request(12); drain();
    check(applied_ratio_o == 12, "R2 applied", applied_ratio_o, 12);
    expect_up(24, "R12");  sw_request(24); drain();

    // throttling caps to the thermal ratio
    expect_down(16, "R4");
    @(negedge clk); throttle_i = 1'b1; therm_ratio_i = 8'd16;
    drain();
    sw_request(28);
    repeat (20) @(negedge clk);
    check(applied_ratio_o == 16 && !volt_req_o && !freq_req_o, "R4 deferred",
          applied_ratio_o, 16);
    expect_down(10, "R5"); sw_request(10); drain();
    check(applied_ratio_o == 10, "R5 applied", applied_ratio_o, 10);
    expect_up(16, "R4");   sw_request(28); drain();
    expect_up(28, "R6");
    @(negedge clk); throttle_i = 1'b0;
    drain();
    check(applied_ratio_o == 28, "R6 applied", applied_ratio_o, 28);

    // floor clamp of the thermal ratio
    expect_down(8, "R7");
    @(negedge clk); throttle_i = 1'b1; therm_ratio_i = 8'd4;
    drain();
    check(applied_ratio_o == 8, "R7 thermal floor", applied_ratio_o, 8);
    check(at_min_o == 1'b1, "R10 at_min set", at_min_o, 1);
    expect_up(28, "R6");
    @(negedge clk); throttle_i = 1'b0;
    drain();
    check(at_min_o == 1'b0, "R10 at_min clear", at_min_o, 0);
    // floor clamp of the software ratio
    expect_down(8, "R7"); sw_request(3); drain();
    check(applied_ratio_o == 8, "R7 sw floor", applied_ratio_o, 8);
    check(at_min_o == 1'b0, "R10 unthrottled floor", at_min_o, 0);

    // R9 new target during a transition
    delay = 6;
    expect_up(20, "R9");
    expect_down(12, "R9");
    sw_request(20);
    @(negedge clk);
    sw_request(12);
    drain();
    check(applied_ratio_o == 12, "R9 applied", applied_ratio_o, 12);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule